// File: doc/BRIEF.md
# PWM Output Brake Controller

This block sits between a multi-channel PWM generator and the output pins. When a fault input is raised it records a brake event per channel, drives each channel's pin to a safe level chosen by that channel's action code, and raises per-channel interrupt flags. Two fault inputs feed it, and the two behave differently:

- **Edge fault input.** It latches a brake that stays in force until software acknowledges the event.
- **Level fault input.** It holds a brake only while the condition lasts.

The raw PWM values pass through unchanged whenever a channel is not braked.

Release from any brake is tied to the PWM period boundary. The block watches the period counter and treats the clock on which the counter changes from a nonzero value to zero as the start of a period.

- **Edge brake.** A channel is released at the first period start at which its edge flag is already clear.
- **Level brake.** A channel is released at the first period start at which the synchronised level fault is inactive. The level interrupt flag plays no part in this release.

Software clears the flags through a write strobe with write-1-to-clear masks.

Top module: `pwm_brake_guard`

## Requirements
- R1: After reset all interrupt flags and brake status bits are 0, and `pwm_out` equals `pwm_raw`.
- R2: Each fault input passes through a two-flop synchroniser. A 0-to-1 transition on `fault_edge_in` sets `edge_flag` and `edge_brake_sts` of every channel three clocks after the input is sampled. Holding the input high does not set them again after they are cleared.
- R3: `edge_flag[c]` is cleared only by a clock with `clr_we`=1 and `clr_edge_flag[c]`=1. That write does not change `edge_brake_sts[c]`.
- R4: `edge_brake_sts[c]` clears on the first period start (`period_cnt` becomes 0 after a nonzero value) at which `edge_flag[c]` is already 0. A period start while the flag is still set leaves the status set.
- R5: While the synchronised `fault_level_in` is 1, `level_flag` and `level_brake_sts` of every channel are set on every clock.
- R6: A clear write with `clr_level_flag[c]`=1 clears `level_flag[c]` only. It has no effect on `level_brake_sts[c]`.
- R7: `level_brake_sts[c]` clears at a period start when the synchronised level fault is inactive, whatever the value of `level_flag[c]`. It stays set across a period start while the fault is active.
- R8: When a new brake event and a clear write for the same flag land on the same clock, the flag stays set.
- R9: Each channel's action code is `brake_act[2c+1:2c]`. While either status bit of channel c is set, code 2'b11 drives `pwm_out[c]` to 1 and code 2'b10 drives it to 0. Codes 2'b00 and 2'b01 pass `pwm_raw[c]` through. With no status bit set, `pwm_raw[c]` always passes through.
- R10: Flags and status bits of different channels are independent. Clearing one channel's flag releases only that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| period_cnt | input | 16 | PWM period counter from the generator |
| pwm_raw | input | 2 | Raw PWM channel values |
| fault_edge_in | input | 1 | Asynchronous fault input, edge-detected |
| fault_level_in | input | 1 | Asynchronous fault input, level-detected |
| brake_act | input | 4 | Per-channel brake action codes, 2 bits per channel |
| clr_we | input | 1 | Flag clear write strobe |
| clr_edge_flag | input | 2 | Write-1-to-clear mask for the edge flags |
| clr_level_flag | input | 2 | Write-1-to-clear mask for the level flags |
| pwm_out | output | 2 | Gated PWM pins |
| edge_flag | output | 2 | Edge brake interrupt flags |
| level_flag | output | 2 | Level brake interrupt flags |
| edge_brake_sts | output | 2 | Edge brake status per channel |
| level_brake_sts | output | 2 | Level brake status per channel |

## Verification
A wrong internal state shows up at the ports right away, because the flags and status bits are outputs.

- **Stuck-set status.** A channel's pin stays at its action level one period longer than the requirement allows. This is visible on the clock right after the period start.
- **Wrong synchroniser depth.** The flags rise a clock early or late, so the bench samples at exactly three clocks.
- **Priority mistakes between set and clear.** These show up as a flag that reads 0 on the clock after a coinciding event.

// File: rtl/pwm_brake_pkg.sv
package pwm_brake_pkg;

  typedef enum logic [1:0] {
    ACT_PASS_A   = 2'b00,
    ACT_PASS_B   = 2'b01,
    ACT_DRIVE_LO = 2'b10,
    ACT_DRIVE_HI = 2'b11
  } brake_act_e;

  function automatic logic act_forces(input brake_act_e a);
    return (a == ACT_DRIVE_HI) || (a == ACT_DRIVE_LO);
  endfunction

  function automatic logic act_level(input brake_act_e a);
    return (a == ACT_DRIVE_HI);
  endfunction

endpackage

// File: rtl/brake_sync.sv
module brake_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          EDGE_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic detect_out
);

  localparam int unsigned CHAIN_W = STAGES + (EDGE_MODE ? 1 : 0);

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  generate
    if (EDGE_MODE) begin : g_edge
      assign detect_out = chain_q[STAGES-1] & ~chain_q[STAGES];

      AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        detect_out |=> !detect_out); // R2
    end else begin : g_level
      assign detect_out = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/period_start_det.sv
module period_start_det #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cnt,
  output logic             period_start
);

  logic nz_q;
  logic nz_d;
  logic cnt_zero;

  assign cnt_zero = (period_cnt == '0);

  always_comb begin
    nz_d = ~cnt_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nz_q <= 1'b0;
    else        nz_q <= nz_d;
  end

  assign period_start = cnt_zero & nz_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start); // R4

endmodule

// File: rtl/brake_chan.sv
module brake_chan
  import pwm_brake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edge_fire,
  input  logic       lvl_active,
  input  logic       period_start,
  input  logic       clr_we,
  input  logic       clr_edge,
  input  logic       clr_lvl,
  input  logic [1:0] act_code,
  input  logic       pwm_raw,
  output logic       pwm_out,
  output logic       edge_irq,
  output logic       lvl_irq,
  output logic       edge_sts,
  output logic       lvl_sts
);

  logic edge_irq_q, edge_irq_d, edge_irq_en;
  logic edge_sts_q, edge_sts_d, edge_sts_en;
  logic lvl_irq_q,  lvl_irq_d,  lvl_irq_en;
  logic lvl_sts_q,  lvl_sts_d,  lvl_sts_en;
  logic edge_wr_clr, lvl_wr_clr;
  logic braked;
  brake_act_e act;

  assign edge_wr_clr = clr_we & clr_edge;
  assign lvl_wr_clr  = clr_we & clr_lvl;

  // next-state: setting always outranks clearing
  always_comb begin
    edge_irq_en = edge_fire | edge_wr_clr;
    edge_irq_d  = edge_fire;

    edge_sts_en = edge_fire | (period_start & ~edge_irq_q);
    edge_sts_d  = edge_fire;

    lvl_irq_en  = lvl_active | lvl_wr_clr;
    lvl_irq_d   = lvl_active;

    lvl_sts_en  = lvl_active | period_start;
    lvl_sts_d   = lvl_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_irq_q <= 1'b0;
      edge_sts_q <= 1'b0;
      lvl_irq_q  <= 1'b0;
      lvl_sts_q  <= 1'b0;
    end else begin
      if (edge_irq_en) edge_irq_q <= edge_irq_d;
      if (edge_sts_en) edge_sts_q <= edge_sts_d;
      if (lvl_irq_en)  lvl_irq_q  <= lvl_irq_d;
      if (lvl_sts_en)  lvl_sts_q  <= lvl_sts_d;
    end
  end

  assign act    = brake_act_e'(act_code);
  assign braked = edge_sts_q | lvl_sts_q;

  always_comb begin
    if (braked && act_forces(act)) pwm_out = act_level(act);
    else                           pwm_out = pwm_raw;
  end

  assign edge_irq = edge_irq_q;
  assign edge_sts = edge_sts_q;
  assign lvl_irq  = lvl_irq_q;
  assign lvl_sts  = lvl_sts_q;

  AST_EDGE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fire |=> (edge_irq_q && edge_sts_q)); // R2

  AST_EDGE_FLAG_CLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edge_irq_q) |-> $past(clr_we && clr_edge)); // R3

  AST_EDGE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edge_sts_q) |-> ($past(period_start) && !$past(edge_irq_q))); // R4

  AST_LVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_active |=> (lvl_irq_q && lvl_sts_q)); // R5

  AST_LVL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_sts_q) |-> ($past(period_start) && !$past(lvl_active))); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_fire && clr_we && clr_edge) |=> edge_irq_q); // R8

  AST_UNBRAKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_sts_q || lvl_sts_q) |-> (pwm_out == pwm_raw)); // R9

endmodule

// File: rtl/pwm_brake_guard.sv
module pwm_brake_guard #(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    period_cnt,
  input  logic [NUM_CH-1:0]   pwm_raw,
  input  logic                fault_edge_in,
  input  logic                fault_level_in,
  input  logic [2*NUM_CH-1:0] brake_act,
  input  logic                clr_we,
  input  logic [NUM_CH-1:0]   clr_edge_flag,
  input  logic [NUM_CH-1:0]   clr_level_flag,
  output logic [NUM_CH-1:0]   pwm_out,
  output logic [NUM_CH-1:0]   edge_flag,
  output logic [NUM_CH-1:0]   level_flag,
  output logic [NUM_CH-1:0]   edge_brake_sts,
  output logic [NUM_CH-1:0]   level_brake_sts
);

  localparam int unsigned ACT_W = 2;

  logic edge_fire;
  logic lvl_active;
  logic period_start;

  brake_sync #(.STAGES(SYNC_STAGES), .EDGE_MODE(1'b1)) i_edge_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (fault_edge_in),
    .detect_out (edge_fire)
  );

  brake_sync #(.STAGES(SYNC_STAGES), .EDGE_MODE(1'b0)) i_level_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (fault_level_in),
    .detect_out (lvl_active)
  );

  period_start_det #(.CNT_W(CNT_W)) i_period (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_cnt   (period_cnt),
    .period_start (period_start)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      brake_chan i_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_fire    (edge_fire),
        .lvl_active   (lvl_active),
        .period_start (period_start),
        .clr_we       (clr_we),
        .clr_edge     (clr_edge_flag[c]),
        .clr_lvl      (clr_level_flag[c]),
        .act_code     (brake_act[ACT_W*c +: ACT_W]),
        .pwm_raw      (pwm_raw[c]),
        .pwm_out      (pwm_out[c]),
        .edge_irq     (edge_flag[c]),
        .lvl_irq      (level_flag[c]),
        .edge_sts     (edge_brake_sts[c]),
        .lvl_sts      (level_brake_sts[c])
      );
    end
  endgenerate

  AST_LVL_CLR_KEEPS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !period_start) |=> (level_brake_sts >= $past(level_brake_sts) ||
                                   level_brake_sts == $past(level_brake_sts))); // R6

  AST_CH_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_fire && !clr_we) |=> $stable(edge_flag)); // R10

endmodule

// File: tb/test_pwm_brake_guard.sv
module test_pwm_brake_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [15:0]      period_cnt;
  logic [NCH-1:0]   pwm_raw;
  logic             fault_edge_in;
  logic             fault_level_in;
  logic [2*NCH-1:0] brake_act;
  logic             clr_we;
  logic [NCH-1:0]   clr_edge_flag;
  logic [NCH-1:0]   clr_level_flag;
  logic [NCH-1:0]   pwm_out;
  logic [NCH-1:0]   edge_flag;
  logic [NCH-1:0]   level_flag;
  logic [NCH-1:0]   edge_brake_sts;
  logic [NCH-1:0]   level_brake_sts;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_brake_guard i_pwm_brake_guard (
    .clk             (clk),
    .rst_n           (rst_n),
    .period_cnt      (period_cnt),
    .pwm_raw         (pwm_raw),
    .fault_edge_in   (fault_edge_in),
    .fault_level_in  (fault_level_in),
    .brake_act       (brake_act),
    .clr_we          (clr_we),
    .clr_edge_flag   (clr_edge_flag),
    .clr_level_flag  (clr_level_flag),
    .pwm_out         (pwm_out),
    .edge_flag       (edge_flag),
    .level_flag      (level_flag),
    .edge_brake_sts  (edge_brake_sts),
    .level_brake_sts (level_brake_sts)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wrap_period();
    period_cnt = 16'd0;
    tick(1);
    period_cnt = 16'd5;
  endtask

  task automatic clear_edge(input logic [NCH-1:0] m);
    clr_we = 1'b1; clr_edge_flag = m;
    tick(1);
    clr_we = 1'b0; clr_edge_flag = '0;
  endtask

  task automatic clear_level(input logic [NCH-1:0] m);
    clr_we = 1'b1; clr_level_flag = m;
    tick(1);
    clr_we = 1'b0; clr_level_flag = '0;
  endtask

  function automatic logic [NCH-1:0] expect_out(input logic [2*NCH-1:0] act,
                                                 input logic [NCH-1:0] raw,
                                                 input logic [NCH-1:0] braked);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++)
      r[c] = (braked[c] && act[2*c+1]) ? act[2*c] : raw[c];
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; period_cnt = 16'd5; pwm_raw = 2'b10;
    fault_edge_in = 1'b0; fault_level_in = 1'b0;
    brake_act = 4'b1011; clr_we = 1'b0;
    clr_edge_flag = '0; clr_level_flag = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 flags", {edge_flag, level_flag, edge_brake_sts, level_brake_sts}, 8'h00);
    chk("R1 out", pwm_out, 2'b10);

    // edge brake: ch1 code 10 (low), ch0 code 11 (high), raw = 10
    fault_edge_in = 1'b1;
    tick(2);
    chk("R2 latency", edge_flag, 2'b00);
    tick(1);
    fault_edge_in = 1'b0;
    chk("R2 flag", edge_flag, 2'b11);
    chk("R2 sts", edge_brake_sts, 2'b11);
    chk("R9 forced", pwm_out, 2'b01);

    wrap_period();
    chk("R4 wrap with flag set", edge_brake_sts, 2'b11);

    clear_edge(2'b01);
    chk("R3 flag ch0 cleared", edge_flag, 2'b10);
    chk("R3 sts untouched", edge_brake_sts, 2'b11);
    tick(2);
    chk("R4 no release before period", edge_brake_sts, 2'b11);
    wrap_period();
    chk("R10 ch0 released only", edge_brake_sts, 2'b10);
    chk("R10 out", pwm_out, 2'b00);
    pwm_raw = 2'b11;
    tick(1);
    chk("R9 ch0 pass ch1 low", pwm_out, 2'b01);

    clear_edge(2'b10);
    wrap_period();
    chk("R4 ch1 released", edge_brake_sts, 2'b00);
    chk("R9 unbraked pass", pwm_out, 2'b11);

    // held-high edge input does not fire again
    fault_edge_in = 1'b1;
    tick(3);
    chk("R2 held set", edge_flag, 2'b11);
    clear_edge(2'b11);
    tick(4);
    chk("R2 no refire", edge_flag, 2'b00);
    fault_edge_in = 1'b0;
    wrap_period();
    chk("R4 released after held", edge_brake_sts, 2'b00);

    // set beats clear on the same clock
    fault_edge_in = 1'b1;
    tick(2);
    clr_we = 1'b1; clr_edge_flag = 2'b11;
    tick(1);
    clr_we = 1'b0; clr_edge_flag = '0;
    fault_edge_in = 1'b0;
    chk("R8 set wins", edge_flag, 2'b11);
    clear_edge(2'b11);
    wrap_period();
    chk("R4 cleanup", edge_brake_sts, 2'b00);

    // level brake
    brake_act = 4'b1111; pwm_raw = 2'b00;
    fault_level_in = 1'b1;
    tick(3);
    chk("R5 level flag", level_flag, 2'b11);
    chk("R5 level sts", level_brake_sts, 2'b11);
    chk("R9 level forced high", pwm_out, 2'b11);
    chk("R5 edge untouched", edge_flag, 2'b00);
    clear_level(2'b11);
    chk("R8 level flag re-set while active", level_flag, 2'b11);
    wrap_period();
    chk("R7 held while active", level_brake_sts, 2'b11);
    fault_level_in = 1'b0;
    tick(3);
    clear_level(2'b11);
    chk("R6 flag cleared", level_flag, 2'b00);
    chk("R6 sts kept", level_brake_sts, 2'b11);
    tick(2);
    chk("R6 sts still kept", level_brake_sts, 2'b11);
    wrap_period();
    chk("R7 released", level_brake_sts, 2'b00);
    chk("R7 out pass", pwm_out, 2'b00);

    // level release regardless of flag
    fault_level_in = 1'b1;
    tick(3);
    fault_level_in = 1'b0;
    tick(3);
    wrap_period();
    chk("R7 release with flag set sts", level_brake_sts, 2'b00);
    chk("R7 release with flag set flag", level_flag, 2'b11);
    clear_level(2'b11);

    // sweep of action codes and raw values under a level brake
    for (int a = 0; a < 16; a++) begin
      for (int r = 0; r < 4; r++) begin
        brake_act = a[3:0]; pwm_raw = r[1:0];
        tick(1);
        chk("R9 sweep unbraked", pwm_out, expect_out(a[3:0], r[1:0], 2'b00));
        fault_level_in = 1'b1;
        tick(3);
        chk("R9 sweep braked", pwm_out, expect_out(a[3:0], r[1:0], 2'b11));
        fault_level_in = 1'b0;
        tick(3);
        wrap_period();
        clear_level(2'b11);
      end
    end
    chk("R7 sweep end", level_brake_sts, 2'b00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule